// File: doc/BRIEF.md
# Fault-Counted Hysteresis Thermostat

This block decides the level of a thermostat output from a stream of temperature conversion results. Each time the converter signals a finished conversion, the new 16-bit two's-complement reading is compared, as a signed number, against an over-temperature limit and a lower hysteresis limit. Only as many upper bits of each limit take part as the current conversion resolution provides. The output only switches once a run of consecutive qualifying readings has been seen. The required run length is chosen by a 2-bit fault-tolerance code.

Two policies are offered. In comparator mode the output works like a thermostat with hysteresis. It goes active after the run of over-limit readings and drops on the first reading under the hysteresis limit. In interrupt mode the output is a latched event flag. It is cleared by any register read or by entering shutdown, and it alternates between reporting over-limit runs and under-hysteresis runs. A polarity input selects whether the active level is high or low. The limit registers themselves and bus access to them sit outside this block. The limits arrive as plain inputs.

Top module: `thermo_trip`

## Requirements
- R1: The fault code `fault_sel` maps 00, 01, 10 and 11 to runs of 1, 2, 4 and 6 consecutive qualifying conversions. The output changes in the cycle after the clock edge that samples `conv_done` high for the last reading of the run. Conversions short of the run leave the output unchanged.
- R2: A conversion that does not qualify resets the run count to zero. A broken run then needs the full count again.
- R3: In comparator mode (`irq_mode`=0), a reading qualifies for activation when signed `temp_in` >= the masked over-temperature limit. Once active, the output stays active through readings at or above the masked hysteresis limit. It goes inactive on the first reading with signed `temp_in` < that limit, with no run needed.
- R4: In interrupt mode (`irq_mode`=1), once active the output ignores further conversions. It stays active until a cycle with `reg_rd`=1 or `shutdown`=1 clears it on the next edge.
- R5: In interrupt mode, after power-up or a mode change, the first activation needs a run of over-limit readings. After each clear, the target flips, so the next activation needs a run of readings with signed `temp_in` < the masked hysteresis limit, then over-limit again, and so on.
- R6: In interrupt mode, while `shutdown`=1 the output is inactive, the run count is held at zero and conversions are ignored. In comparator mode `shutdown` has no effect on the output.
- R7: The resolution code `res_sel` = 00, 01, 10 and 11 means 9, 10, 11 and 12 bits. Both limits are masked to their top 9+`res_sel` bits (lower bits forced to zero) before comparison. `temp_in` is used as given.
- R8: With `act_high`=0 the pin is 0 when active and 1 when inactive. With `act_high`=1 it is the opposite. A polarity change reaches the pin without a clock edge.
- R9: Both comparisons are signed two's-complement. For example, with a -0.5 degree limit (0xFF80), a reading of 0x0000 is over the limit.
- R10: A change of `irq_mode` clears the output to inactive, zeroes the run count and re-arms the over-limit target on the next edge. No conversion is counted in that cycle.
- R11: After reset the output is inactive, the run count is zero and the target is over-limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: `temp_in` holds a new reading |
| temp_in | input | 16 | Conversion result, two's complement, 1/256 degree per LSB |
| lim_over | input | 16 | Over-temperature limit, same format |
| lim_hyst | input | 16 | Hysteresis limit, same format |
| res_sel | input | 2 | Resolution code, 9 to 12 bits |
| fault_sel | input | 2 | Fault-tolerance code, run length 1/2/4/6 |
| irq_mode | input | 1 | 0 comparator mode, 1 interrupt mode |
| act_high | input | 1 | 0 active-low output, 1 active-high output |
| shutdown | input | 1 | Shutdown request |
| reg_rd | input | 1 | One-cycle strobe: a register read took place |
| trip_pin | output | 1 | Thermostat output level |

## Verification
The bound checker watches several rules on every cycle:
- In comparator mode the state stays unchanged without a conversion.
- In comparator mode a reading under the hysteresis limit releases an active output.
- In interrupt mode an active output holds until a read or shutdown.
- In interrupt mode shutdown forces the output inactive.
- A mode change clears everything.
- The run counter never passes the longest run.

Only the bench's scenarios can show that the run lengths are exact for each code and that a broken run starts over. The same goes for limit masking at each resolution, signed ordering across zero, the alternation of over and under targets in interrupt mode, and immediate polarity response.

// File: rtl/thermo_trip_pkg.sv
package thermo_trip_pkg;
  localparam int RUN_W = 3;

  function automatic logic [RUN_W-1:0] run_need(input logic [1:0] code);
    case (code)
      2'b00:   run_need = 3'd1;
      2'b01:   run_need = 3'd2;
      2'b10:   run_need = 3'd4;
      default: run_need = 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/trip_limit_cmp.sv
module trip_limit_cmp #(
  parameter int DW      = 16,
  parameter int MIN_RES = 9,
  parameter int RES_W   = 2
) (
  input  logic [DW-1:0]    sample,
  input  logic [DW-1:0]    lim_hi,
  input  logic [DW-1:0]    lim_lo,
  input  logic [RES_W-1:0] res,
  output logic             over,
  output logic             under
);
  localparam int BASE_SH = DW - MIN_RES;

  logic [DW-1:0] keep_mask;
  logic [DW-1:0] hi_m;
  logic [DW-1:0] lo_m;

  always_comb begin
    keep_mask = {DW{1'b1}} << (BASE_SH - int'(res));
    hi_m      = lim_hi & keep_mask;
    lo_m      = lim_lo & keep_mask;
    over      = $signed(sample) >= $signed(hi_m);
    under     = $signed(sample) <  $signed(lo_m);
  end
endmodule

// File: rtl/trip_run_counter.sv
module trip_run_counter #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          qual,
  input  logic          clr,
  input  logic [CW-1:0] need,
  output logic [CW-1:0] cnt_q,
  output logic          hit
);
  logic [CW:0]   cnt_inc;
  logic [CW-1:0] cnt_d;
  logic          cnt_ld;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    hit     = en && qual && (cnt_inc >= {1'b0, need});
    cnt_ld  = clr || en;
    if (clr)
      cnt_d = '0;
    else if (qual && !hit)
      cnt_d = cnt_inc[CW-1:0];
    else
      cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_ld)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/trip_mode_fsm.sv
module trip_mode_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic conv,
  input  logic over,
  input  logic under,
  input  logic hit,
  input  logic irq_mode,
  input  logic shutdown,
  input  logic reg_rd,
  output logic active_q,
  output logic seek_hi_q,
  output logic mode_q,
  output logic cnt_en,
  output logic cnt_qual,
  output logic cnt_clr
);
  logic active_d;
  logic seek_hi_d;
  logic mode_chg;

  always_comb begin
    mode_chg  = irq_mode != mode_q;
    active_d  = active_q;
    seek_hi_d = seek_hi_q;
    cnt_en    = 1'b0;
    cnt_qual  = 1'b0;
    cnt_clr   = 1'b0;
    if (mode_chg) begin
      active_d  = 1'b0;
      seek_hi_d = 1'b1;
      cnt_clr   = 1'b1;
    end else if (!irq_mode) begin
      if (!active_q) begin
        cnt_en   = conv;
        cnt_qual = over;
        if (hit) active_d = 1'b1;
      end else if (conv && under) begin
        active_d = 1'b0;
      end
    end else begin
      if (shutdown) begin
        active_d = 1'b0;
        cnt_clr  = 1'b1;
      end else if (active_q) begin
        if (reg_rd) active_d = 1'b0;
      end else begin
        cnt_en   = conv;
        cnt_qual = seek_hi_q ? over : under;
        if (hit) begin
          active_d  = 1'b1;
          seek_hi_d = !seek_hi_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      seek_hi_q <= 1'b1;
      mode_q    <= 1'b0;
    end else begin
      active_q  <= active_d;
      seek_hi_q <= seek_hi_d;
      mode_q    <= irq_mode;
    end
  end
endmodule

// File: rtl/thermo_trip.sv
module thermo_trip
  import thermo_trip_pkg::*;
#(
  parameter int DW      = 16,
  parameter int MIN_RES = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [DW-1:0] temp_in,
  input  logic [DW-1:0] lim_over,
  input  logic [DW-1:0] lim_hyst,
  input  logic [1:0]    res_sel,
  input  logic [1:0]    fault_sel,
  input  logic          irq_mode,
  input  logic          act_high,
  input  logic          shutdown,
  input  logic          reg_rd,
  output logic          trip_pin
);
  logic             over_hit;
  logic             under_hit;
  logic             run_en;
  logic             run_qual;
  logic             run_clr;
  logic             run_hit;
  logic [RUN_W-1:0] run_cnt;
  logic [RUN_W-1:0] run_len;
  logic             trip_active;
  logic             seek_hi;
  logic             mode_seen;

  assign run_len = run_need(fault_sel);

  trip_limit_cmp #(.DW(DW), .MIN_RES(MIN_RES), .RES_W(2)) u_cmp (
    .sample (temp_in),
    .lim_hi (lim_over),
    .lim_lo (lim_hyst),
    .res    (res_sel),
    .over   (over_hit),
    .under  (under_hit)
  );

  trip_run_counter #(.CW(RUN_W)) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run_en),
    .qual  (run_qual),
    .clr   (run_clr),
    .need  (run_len),
    .cnt_q (run_cnt),
    .hit   (run_hit)
  );

  trip_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv      (conv_done),
    .over      (over_hit),
    .under     (under_hit),
    .hit       (run_hit),
    .irq_mode  (irq_mode),
    .shutdown  (shutdown),
    .reg_rd    (reg_rd),
    .active_q  (trip_active),
    .seek_hi_q (seek_hi),
    .mode_q    (mode_seen),
    .cnt_en    (run_en),
    .cnt_qual  (run_qual),
    .cnt_clr   (run_clr)
  );

  assign trip_pin = act_high ? trip_active : !trip_active;
endmodule

// File: rtl/thermo_trip_chk.sv
module thermo_trip_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_done,
  input logic       irq_mode,
  input logic       shutdown,
  input logic       reg_rd,
  input logic       under_hit,
  input logic       trip_active,
  input logic       mode_seen,
  input logic [2:0] run_cnt
);
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= 3'd5);  // R1

  AST_CMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mode && !mode_seen && !conv_done) |=> $stable(trip_active));  // R3

  AST_CMP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mode && !mode_seen && trip_active && conv_done && under_hit) |=> !trip_active);  // R3

  AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode && mode_seen && trip_active && !shutdown && !reg_rd) |=> trip_active);  // R4

  AST_IRQ_SHDN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode && shutdown) |=> !trip_active);  // R6

  AST_MODE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode != mode_seen) |=> (!trip_active && run_cnt == 3'd0));  // R10
endmodule

bind thermo_trip thermo_trip_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_done   (conv_done),
  .irq_mode    (irq_mode),
  .shutdown    (shutdown),
  .reg_rd      (reg_rd),
  .under_hit   (under_hit),
  .trip_active (trip_active),
  .mode_seen   (mode_seen),
  .run_cnt     (run_cnt)
);

// File: tb/thermo_trip_test.sv
`timescale 1ns/1ps
module thermo_trip_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv_done, irq_mode, act_high, shutdown, reg_rd;
  logic [15:0] temp_in, lim_over, lim_hyst;
  logic [1:0]  res_sel, fault_sel;
  logic        trip_pin;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference state
  bit m_act, m_seek, m_mode;
  int m_cnt;

  always #2 clk = ~clk;

  thermo_trip uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp_in(temp_in),
    .lim_over(lim_over), .lim_hyst(lim_hyst), .res_sel(res_sel),
    .fault_sel(fault_sel), .irq_mode(irq_mode), .act_high(act_high),
    .shutdown(shutdown), .reg_rd(reg_rd), .trip_pin(trip_pin)
  );

  function automatic int need_of(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic logic [15:0] lim_mask(input logic [15:0] v, input logic [1:0] r);
    logic [15:0] m;
    m = 16'hFFFF << (7 - int'(r));
    return v & m;
  endfunction

  function automatic bit is_over(input logic [15:0] t);
    return $signed(t) >= $signed(lim_mask(lim_over, res_sel));
  endfunction

  function automatic bit is_under(input logic [15:0] t);
    return $signed(t) < $signed(lim_mask(lim_hyst, res_sel));
  endfunction

  function automatic logic exp_pin();
    return act_high ? m_act : !m_act;
  endfunction

  // count one qualifying or breaking reading; returns 1 when the run completes
  function automatic bit count_step(input bit q);
    if (q) begin
      if (m_cnt + 1 >= need_of(fault_sel)) begin
        m_cnt = 0;
        return 1;
      end
      m_cnt = m_cnt + 1;
    end else begin
      m_cnt = 0;
    end
    return 0;
  endfunction

  task automatic model_edge();
    if (irq_mode != m_mode) begin
      m_act = 0; m_seek = 1; m_cnt = 0;
    end else if (!irq_mode) begin
      if (!m_act) begin
        if (conv_done && count_step(is_over(temp_in))) m_act = 1;
      end else if (conv_done && is_under(temp_in)) begin
        m_act = 0;
      end
    end else begin
      if (shutdown) begin
        m_act = 0; m_cnt = 0;
      end else if (m_act) begin
        if (reg_rd) m_act = 0;
      end else if (conv_done) begin
        if (count_step(m_seek ? is_over(temp_in) : is_under(temp_in))) begin
          m_act = 1; m_seek = !m_seek;
        end
      end
    end
    m_mode = irq_mode;
  endtask

  task automatic check(input string tag);
    vectors++;
    if (trip_pin !== exp_pin()) begin
      errors++;
      $display("FAIL %s: trip_pin=%0b expected %0b at %0t", tag, trip_pin, exp_pin(), $time);
    end
  endtask

  // apply one cycle of stimulus from a negedge, check at the following negedge
  task automatic apply(input logic cv, input logic [15:0] t, input logic rd, input string tag);
    conv_done = cv; temp_in = t; reg_rd = rd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    conv_done = 1'b0; reg_rd = 1'b0;
    check(tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; conv_done = 0; reg_rd = 0; irq_mode = 0; act_high = 0; shutdown = 0;
    temp_in = 16'h0; lim_over = 16'h5000; lim_hyst = 16'h4B00; res_sel = 2'd3; fault_sel = 2'd0;
    m_act = 0; m_seek = 1; m_mode = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check("R11 reset inactive");
    rst_n = 1;
    @(negedge clk);
    check("R11 after release");

    // R1 / R3: run lengths per fault code, hysteresis release
    for (int code = 0; code < 4; code++) begin
      fault_sel = code[1:0];
      apply(1, 16'h4000, 0, "R3 start low");
      for (int k = 0; k < need_of(code[1:0]) - 1; k++)
        apply(1, 16'h5100, 0, "R1 short of run");
      apply(1, 16'h5100, 0, "R1 run completes");
      if (trip_pin !== act_high) begin
        errors++; $display("FAIL R1: code %0d did not activate, pin=%0b expected %0b", code, trip_pin, act_high);
      end
      vectors++;
      apply(1, 16'h4C00, 0, "R3 hold inside band");
      apply(1, 16'h4B00, 0, "R3 hold at hysteresis limit");
      apply(1, 16'h4AF0, 0, "R3 release below hysteresis");
    end

    // R2: broken run restarts
    fault_sel = 2'd2;
    repeat (3) apply(1, 16'h5000, 0, "R2 partial run");
    apply(1, 16'h4F00, 0, "R2 break");
    repeat (3) apply(1, 16'h5000, 0, "R2 restarted run");
    apply(1, 16'h5000, 0, "R2 fourth after break");
    apply(1, 16'h4000, 0, "R2 release");

    // R7: masking of limits by resolution
    fault_sel = 2'd0; lim_over = 16'h5070;
    res_sel = 2'd3;
    apply(1, 16'h5000, 0, "R7 12-bit limit not reached");
    res_sel = 2'd0;
    apply(1, 16'h5000, 0, "R7 9-bit masked limit reached");
    apply(1, 16'h4000, 0, "R7 release");
    res_sel = 2'd2; lim_over = 16'h5010;
    apply(1, 16'h5000, 0, "R7 11-bit masks low nibble");
    apply(1, 16'h4000, 0, "R7 release");
    res_sel = 2'd3; lim_over = 16'h5000;

    // R9: signed limits
    lim_over = 16'hFF80; lim_hyst = 16'hFB00;
    apply(1, 16'h0000, 0, "R9 zero above -0.5");
    apply(1, 16'hFC00, 0, "R9 -4 inside band");
    apply(1, 16'hFA00, 0, "R9 -6 below -5");
    apply(1, 16'h8000, 0, "R9 most negative not over");
    lim_over = 16'h5000; lim_hyst = 16'h4B00;

    // R8: polarity reaches pin without a clock
    apply(1, 16'h6000, 0, "R8 activate");
    act_high = 1; #1; check("R8 active high");
    act_high = 0; #1; check("R8 active low");
    @(negedge clk);

    // R10 then R4/R5 interrupt mode
    irq_mode = 1; fault_sel = 2'd1;
    apply(0, 16'h0, 0, "R10 mode change clears");
    apply(1, 16'h6000, 0, "R5 first over");
    apply(1, 16'h6000, 0, "R5 over run done");
    apply(1, 16'h4000, 0, "R4 ignores conversions while active");
    apply(0, 16'h0, 1, "R4 read clears");
    apply(1, 16'h6000, 0, "R5 over ignored after clear");
    apply(1, 16'h6000, 0, "R5 over still ignored");
    apply(1, 16'h4000, 0, "R5 first under");
    apply(1, 16'h4000, 0, "R5 under run done");
    apply(0, 16'h0, 1, "R4 read clears again");
    apply(1, 16'h6000, 0, "R5 over target rearmed");
    apply(1, 16'h6000, 0, "R5 over run done again");

    // R6: shutdown
    shutdown = 1;
    apply(0, 16'h0, 0, "R6 shutdown clears interrupt");
    apply(1, 16'h4000, 0, "R6 conversion ignored in shutdown");
    apply(1, 16'h4000, 0, "R6 still ignored");
    shutdown = 0;
    apply(1, 16'h4000, 0, "R6 run restarts after shutdown");
    irq_mode = 0;
    apply(0, 16'h0, 0, "R10 back to comparator");
    fault_sel = 2'd0;
    apply(1, 16'h6000, 0, "R3 activate");
    shutdown = 1;
    apply(0, 16'h0, 0, "R6 comparator unaffected");
    apply(0, 16'h0, 1, "R6 comparator read no effect");
    shutdown = 0;

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] t;
      int pick;
      if ($urandom_range(0, 60) == 0) irq_mode = !irq_mode;
      if ($urandom_range(0, 40) == 0) fault_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 40) == 0) res_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 50) == 0) act_high = !act_high;
      shutdown = ($urandom_range(0, 30) == 0);
      pick = $urandom_range(0, 3);
      case (pick)
        0: t = lim_over + 16'($signed($urandom_range(0, 64)) - 32);
        1: t = lim_hyst + 16'($signed($urandom_range(0, 64)) - 32);
        2: t = 16'($urandom);
        default: t = 16'h5800;
      endcase
      apply(($urandom_range(0, 3) != 0), t, ($urandom_range(0, 9) == 0),
            irq_mode ? "R4 random interrupt" : "R3 random comparator");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule